// File: doc/BRIEF.md
# Quarter-Duty LCD Drive Level Sequencer

This block produces the drive pattern for a multiplexed liquid-crystal panel with four backplane (common) lines and 41 segment lines, which together address 164 display bits. It does not produce voltages. Every output pin is reported as a 2-bit level code, and a separate analog stage turns that code into the actual rail or bias voltage. The panel contents arrive as a flat bit vector from display memory that sits outside this block. A small control word selects the bias scheme, blanks the segments, puts the driver to sleep, and turns some of the low segment pins into static general-purpose outputs. That control word is captured only when a load strobe is asserted.

Timing comes from an oscillator enable pulse. Each common line is selected in turn for `PHASE_TICKS` enabled pulses. One frame visits all four commons, so with the default setting a frame lasts 512 oscillator periods. The drive polarity flips at the end of every frame, which keeps the average voltage across each pixel at zero.

Level codes: `00` = VSS, `01` = lower intermediate level (1/3 of supply in third bias, the supply midpoint in half bias), `10` = upper intermediate level (2/3 of supply, used only in third bias), `11` = VDD. Pin `k` of `com_lvl` occupies bits `[2k+1:2k]`. Segment pin `s` of `seg_lvl` occupies bits `[2s+1:2s]`. Segment pin `s` shows display bit `disp_mem[4s+k]` while common `k` is selected.

Top module: `lcd_mux_driver`

## Requirements
- R1: After reset the control word is all zero, which means half bias, no blanking, awake, no ports, and port data 0. The sequencer starts at common 0 with polarity 0, so `com_lvl` reads `01_01_01_11` (common 0 at VDD).
- R2: The selected common advances by one after every `PHASE_TICKS` cycles with `osc_en` high. Cycles with `osc_en` low do not advance it. After common 3 the selection wraps to common 0.
- R3: Polarity toggles when the selection wraps from common 3 to common 0, and at no other time while awake.
- R4: The selected common drives `11` under polarity 0 and `00` under polarity 1. A non-selected common drives `01` in half bias. In third bias it drives `01` under polarity 0 and `10` under polarity 1.
- R5: In third bias, a lit segment drives `00` under polarity 0 and `11` under polarity 1. An unlit segment drives `10` under polarity 0 and `01` under polarity 1.
- R6: In half bias, segments use only the rails. A lit segment drives the rail opposite to the selected common, and an unlit segment drives the same rail as the selected common.
- R7: Segment pin `s` is lit during common `k` exactly when `disp_mem[4s+k]` is 1. Changes to `disp_mem` appear on the outputs in the same cycle.
- R8: While the blank bit is set, every segment pin drives the unlit level. Clearing the bit brings back the memory contents, because display memory is never modified.
- R9: A non-zero sleep code drives every common and every segment pin that is not a port to `00`. Sleep also resets the sequencer, so after waking it resumes at common 0 with polarity 0.
- R10: The port-select code decides how many of the low segment pins act as ports: `00` gives none, `01` gives pin 0, `10` gives pins 0 and 1, and `11` gives pins 0 to 3. A port pin drives `11` when its port data bit is 1 and `00` otherwise, whatever the phase, polarity or blank bit.
- R11: Port pins keep driving their latched data while the block sleeps.
- R12: A control word takes effect in the cycle after the `ctrl_load` cycle. Control inputs have no effect while `ctrl_load` is low. A load in the same cycle as a tick completes both the load and the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | Oscillator tick enable; one pulse per oscillator period |
| ctrl_load | input | 1 | Captures the control inputs below at this edge |
| ctrl_bias_third | input | 1 | 1 = third bias, 0 = half bias |
| ctrl_blank | input | 1 | 1 = force all segments to the unlit level |
| ctrl_sleep | input | 2 | Non-zero = sleep |
| ctrl_port_sel | input | 2 | Number of low segment pins used as ports (code per R10) |
| ctrl_port_data | input | 4 | Static value for each port pin |
| disp_mem | input | 164 | Display memory, bit `4s+k` = segment `s` during common `k` |
| com_lvl | output | 8 | Level codes of the four commons |
| seg_lvl | output | 82 | Level codes of the 41 segment pins |

## Verification
The case of interest is a control load that lands in the same cycle as the oscillator tick ending a phase. The bench runs the sequencer until exactly one tick remains in the phase. It then pulses `ctrl_load`, with a new bias, and `osc_en` together. The next cycle must show both the following common selected and the new bias levels. A second case overlaps sleep with port output. Ports are configured, then sleep is loaded, and the bench checks each cycle that the port pins still carry their data while every other pin sits at `00`. After wake-up the sequence must restart at common 0 with polarity 0.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LV_VSS = 2'b00;
  localparam lvl_t LV_LO  = 2'b01;
  localparam lvl_t LV_HI  = 2'b10;
  localparam lvl_t LV_VDD = 2'b11;

  typedef struct packed {
    logic       bias_third;
    logic       blank;
    logic [1:0] sleep;
    logic [1:0] port_sel;
  } ctrl_t;

  // Backplane level for one common line.
  function automatic lvl_t com_level(input logic sel, input logic pol, input logic third);
    if (sel)        return pol ? LV_VSS : LV_VDD;
    else if (third) return pol ? LV_HI : LV_LO;
    else            return LV_LO;
  endfunction

  // Segment level; half bias keeps segments on the rails.
  function automatic lvl_t seg_level(input logic lit, input logic pol, input logic third);
    if (lit)        return pol ? LV_VDD : LV_VSS;
    else if (third) return pol ? LV_LO : LV_HI;
    else            return pol ? LV_VSS : LV_VDD;
  endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int PHASE_TICKS = 128,
  parameter int NUM_COM     = 4,
  localparam int TICK_W     = $clog2(PHASE_TICKS),
  localparam int PHASE_W    = $clog2(NUM_COM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               halt,
  output logic [PHASE_W-1:0] phase_o,
  output logic               pol_o
);

  logic [TICK_W-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || halt) begin
      tick_cnt <= '0;
      phase_o  <= '0;
      pol_o    <= 1'b0;
    end else if (tick) begin
      if (tick_cnt == TICK_W'(PHASE_TICKS - 1)) begin
        tick_cnt <= '0;
        if (phase_o == PHASE_W'(NUM_COM - 1)) begin
          phase_o <= '0;
          pol_o   <= ~pol_o;
        end else begin
          phase_o <= phase_o + 1'b1;
        end
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
  import lcd_pkg::*;
#(
  parameter int NUM_COM = 4,
  localparam int PHASE_W = $clog2(NUM_COM)
) (
  input  logic [PHASE_W-1:0]   phase,
  input  logic                 pol,
  input  logic                 third,
  input  logic                 sleep,
  output logic [2*NUM_COM-1:0] com_lvl
);

  for (genvar k = 0; k < NUM_COM; k++) begin : g_com
    assign com_lvl[2*k +: 2] = sleep ? LV_VSS
                             : com_level(phase == PHASE_W'(k), pol, third);
  end

endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
  import lcd_pkg::*;
#(
  parameter int NUM_COM  = 4,
  parameter int NUM_SEG  = 41,
  parameter int NUM_PORT = 4,
  localparam int PHASE_W  = $clog2(NUM_COM),
  localparam int MEM_BITS = NUM_COM * NUM_SEG
) (
  input  logic [MEM_BITS-1:0]  disp_mem,
  input  logic [PHASE_W-1:0]   phase,
  input  logic                 pol,
  input  logic                 third,
  input  logic                 blank,
  input  logic                 sleep,
  input  logic [NUM_PORT-1:0]  port_en,
  input  logic [NUM_PORT-1:0]  port_dat,
  output logic [2*NUM_SEG-1:0] seg_lvl
);

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_COM-1:0] column;
    logic               lit;
    lvl_t               drv;

    assign column = disp_mem[s*NUM_COM +: NUM_COM];
    assign lit    = column[phase] & ~blank;
    assign drv    = sleep ? LV_VSS : seg_level(lit, pol, third);

    if (s < NUM_PORT) begin : g_port
      assign seg_lvl[2*s +: 2] = port_en[s] ? {2{port_dat[s]}} : drv;
    end else begin : g_plain
      assign seg_lvl[2*s +: 2] = drv;
    end
  end

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
  import lcd_pkg::*;
#(
  parameter int NUM_COM     = 4,
  parameter int NUM_SEG     = 41,
  parameter int NUM_PORT    = 4,
  parameter int PHASE_TICKS = 128,
  localparam int MEM_BITS   = NUM_COM * NUM_SEG,
  localparam int PHASE_W    = $clog2(NUM_COM),
  localparam int PORT_CW    = $clog2(NUM_PORT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 osc_en,
  input  logic                 ctrl_load,
  input  logic                 ctrl_bias_third,
  input  logic                 ctrl_blank,
  input  logic [1:0]           ctrl_sleep,
  input  logic [1:0]           ctrl_port_sel,
  input  logic [NUM_PORT-1:0]  ctrl_port_data,
  input  logic [MEM_BITS-1:0]  disp_mem,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl
);

  ctrl_t               ctrl_q;
  logic [NUM_PORT-1:0] port_q;
  logic                sleep_q;
  logic [PORT_CW-1:0]  port_cnt;
  logic [NUM_PORT-1:0] port_en;
  logic [PHASE_W-1:0]  phase_q;
  logic                pol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      port_q <= '0;
    end else if (ctrl_load) begin
      ctrl_q <= '{bias_third: ctrl_bias_third, blank: ctrl_blank,
                  sleep: ctrl_sleep, port_sel: ctrl_port_sel};
      port_q <= ctrl_port_data;
    end
  end

  assign sleep_q = |ctrl_q.sleep;

  always_comb begin
    unique case (ctrl_q.port_sel)
      2'd0:    port_cnt = '0;
      2'd1:    port_cnt = PORT_CW'(1);
      2'd2:    port_cnt = PORT_CW'(2);
      default: port_cnt = PORT_CW'(NUM_PORT);
    endcase
  end

  for (genvar i = 0; i < NUM_PORT; i++) begin : g_pen
    assign port_en[i] = PORT_CW'(i) < port_cnt;
  end

  lcd_frame_timer #(
    .PHASE_TICKS(PHASE_TICKS),
    .NUM_COM    (NUM_COM)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (osc_en),
    .halt   (sleep_q),
    .phase_o(phase_q),
    .pol_o  (pol_q)
  );

  lcd_com_drive #(
    .NUM_COM(NUM_COM)
  ) u_com (
    .phase  (phase_q),
    .pol    (pol_q),
    .third  (ctrl_q.bias_third),
    .sleep  (sleep_q),
    .com_lvl(com_lvl)
  );

  lcd_seg_drive #(
    .NUM_COM (NUM_COM),
    .NUM_SEG (NUM_SEG),
    .NUM_PORT(NUM_PORT)
  ) u_seg (
    .disp_mem(disp_mem),
    .phase   (phase_q),
    .pol     (pol_q),
    .third   (ctrl_q.bias_third),
    .blank   (ctrl_q.blank),
    .sleep   (sleep_q),
    .port_en (port_en),
    .port_dat(port_q),
    .seg_lvl (seg_lvl)
  );

endmodule

// File: rtl/lcd_mux_driver_chk.sv
module lcd_mux_driver_chk #(
  parameter int NUM_COM  = 4,
  parameter int NUM_SEG  = 41,
  parameter int NUM_PORT = 4,
  localparam int PHASE_W = $clog2(NUM_COM)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 osc_en,
  input logic                 ctrl_load,
  input logic                 ctrl_bias_third,
  input logic [2*NUM_COM-1:0] com_lvl,
  input logic [2*NUM_SEG-1:0] seg_lvl,
  input logic                 sleep_q,
  input logic                 bias_q,
  input logic [PHASE_W-1:0]   phase_q,
  input logic                 pol_q,
  input logic [NUM_PORT-1:0]  port_en,
  input logic [NUM_PORT-1:0]  port_q
);

  logic [NUM_COM-1:0] at_rail;
  for (genvar k = 0; k < NUM_COM; k++) begin : g_rail
    assign at_rail[k] = (com_lvl[2*k +: 2] == 2'b00) || (com_lvl[2*k +: 2] == 2'b11);
  end

  // R4: exactly one common sits on a rail while awake
  a_r4_one_rail_com: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_q |-> $countones(at_rail) == 1);

  // R9: sleep grounds every common
  a_r9_sleep_com_vss: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> com_lvl == '0);

  // R2: no tick, no advance
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !sleep_q) |=> $stable(phase_q));

  // R3: polarity only changes when leaving the last common
  a_r3_pol_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_q && phase_q != PHASE_W'(NUM_COM - 1)) |=> $stable(pol_q));

  // R12: load takes effect next cycle, otherwise holds
  a_r12_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_load |=> bias_q == $past(ctrl_bias_third));
  a_r12_no_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_load |=> $stable(bias_q));

  // R11: ports hold their data during sleep
  for (genvar i = 0; i < NUM_PORT; i++) begin : g_pchk
    a_r11_port_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_q && port_en[i]) |-> seg_lvl[2*i +: 2] == {2{port_q[i]}});
  end

endmodule

bind lcd_mux_driver lcd_mux_driver_chk #(
  .NUM_COM (NUM_COM),
  .NUM_SEG (NUM_SEG),
  .NUM_PORT(NUM_PORT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .osc_en         (osc_en),
  .ctrl_load      (ctrl_load),
  .ctrl_bias_third(ctrl_bias_third),
  .com_lvl        (com_lvl),
  .seg_lvl        (seg_lvl),
  .sleep_q        (sleep_q),
  .bias_q         (ctrl_q.bias_third),
  .phase_q        (phase_q),
  .pol_q          (pol_q),
  .port_en        (port_en),
  .port_q         (port_q)
);

// File: tb/lcd_mux_driver_tb.sv
module lcd_mux_driver_tb;

  localparam int NC = 4;
  localparam int NS = 41;
  localparam int NP = 4;
  localparam int PT = 128;
  localparam int MB = NC * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          osc_en = 1'b0;
  logic          ctrl_load = 1'b0;
  logic          ctrl_bias_third = 1'b0;
  logic          ctrl_blank = 1'b0;
  logic [1:0]    ctrl_sleep = 2'b0;
  logic [1:0]    ctrl_port_sel = 2'b0;
  logic [NP-1:0] ctrl_port_data = '0;
  logic [MB-1:0] mem = '0;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  int n_run = 0;
  int n_fail = 0;
  int t = 0;
  logic          m_third = 0, m_blank = 0;
  logic [1:0]    m_sleep = 0, m_psel = 0;
  logic [NP-1:0] m_pdat = 0;

  always #5 clk = ~clk;

  lcd_mux_driver #(.NUM_COM(NC), .NUM_SEG(NS), .NUM_PORT(NP), .PHASE_TICKS(PT)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .ctrl_load(ctrl_load),
    .ctrl_bias_third(ctrl_bias_third), .ctrl_blank(ctrl_blank),
    .ctrl_sleep(ctrl_sleep), .ctrl_port_sel(ctrl_port_sel),
    .ctrl_port_data(ctrl_port_data), .disp_mem(mem),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl));

  function automatic int nports(input logic [1:0] ps);
    case (ps)
      2'd0: return 0;
      2'd1: return 1;
      2'd2: return 2;
      default: return NP;
    endcase
  endfunction

  function automatic logic [2*NC-1:0] exp_com();
    logic [2*NC-1:0] v;
    int ph = (t / PT) % NC;
    int po = (t / (PT * NC)) % 2;
    for (int k = 0; k < NC; k++) begin
      if (m_sleep != 0)  v[2*k +: 2] = 2'b00;
      else if (k == ph)  v[2*k +: 2] = po ? 2'b00 : 2'b11;
      else if (m_third)  v[2*k +: 2] = po ? 2'b10 : 2'b01;
      else               v[2*k +: 2] = 2'b01;
    end
    return v;
  endfunction

  function automatic logic [2*NS-1:0] exp_seg();
    logic [2*NS-1:0] v;
    int ph = (t / PT) % NC;
    int po = (t / (PT * NC)) % 2;
    for (int s = 0; s < NS; s++) begin
      logic lit;
      if (s < nports(m_psel))   v[2*s +: 2] = {2{m_pdat[s]}};
      else if (m_sleep != 0)    v[2*s +: 2] = 2'b00;
      else begin
        lit = mem[s*NC + ph] && !m_blank;
        if (lit)          v[2*s +: 2] = po ? 2'b11 : 2'b00;
        else if (m_third) v[2*s +: 2] = po ? 2'b01 : 2'b10;
        else              v[2*s +: 2] = po ? 2'b00 : 2'b11;
      end
    end
    return v;
  endfunction

  task automatic check_all(input string tag);
    logic [2*NC-1:0] ec = exp_com();
    logic [2*NS-1:0] es = exp_seg();
    n_run++;
    if (com_lvl !== ec) begin
      n_fail++;
      $display("FAIL %s com_lvl actual %h expected %h (t=%0d)", tag, com_lvl, ec, t);
    end
    n_run++;
    if (seg_lvl !== es) begin
      n_fail++;
      $display("FAIL %s seg_lvl actual %h expected %h (t=%0d)", tag, seg_lvl, es, t);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic cyc(input logic en, input logic load);
    osc_en = en;
    ctrl_load = load;
    @(posedge clk);
    #1;
    if (m_sleep != 0) t = 0;
    else if (en) t++;
    if (load) begin
      m_third = ctrl_bias_third; m_blank = ctrl_blank;
      m_sleep = ctrl_sleep; m_psel = ctrl_port_sel; m_pdat = ctrl_port_data;
    end
    @(negedge clk);
    osc_en = 1'b0;
    ctrl_load = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      cyc((i % 3) != 2, 1'b0);
      check_all(tag);
    end
  endtask

  task automatic load_ctrl(input logic th, input logic bl, input logic [1:0] sl,
                           input logic [1:0] ps, input logic [NP-1:0] pd, input logic en);
    ctrl_bias_third = th; ctrl_blank = bl; ctrl_sleep = sl;
    ctrl_port_sel = ps; ctrl_port_data = pd;
    cyc(en, 1'b1);
  endtask

  task automatic fill_mem(input int seed);
    for (int i = 0; i < MB; i++) mem[i] = ((i * seed + i / 3) % 5) < 2;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    fill_mem(7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset state");
    n_run++;
    if (com_lvl !== 8'b01_01_01_11) begin
      n_fail++;
      $display("FAIL R1 com_lvl actual %b expected %b", com_lvl, 8'b01_01_01_11);
    end

    // R2 R3 R4 R6 R7: half bias over two full frames with gapped ticks
    run(1600, "R2/R3/R4/R6 half bias");
    fill_mem(13);
    run(200, "R7 memory change");

    // R5: third bias
    load_ctrl(1, 0, 2'b00, 2'b00, 4'h0, 1'b0);
    check_all("R5 third bias load");
    run(1600, "R4/R5 third bias");

    // R8: blanking, then restore
    load_ctrl(1, 1, 2'b00, 2'b00, 4'h0, 1'b0);
    run(300, "R8 blank third");
    load_ctrl(0, 1, 2'b00, 2'b00, 4'h0, 1'b0);
    run(300, "R8 blank half");
    load_ctrl(0, 0, 2'b00, 2'b00, 4'h0, 1'b0);
    run(100, "R8 restore");

    // R10: every port-select code with several data patterns
    for (int ps = 0; ps < 4; ps++) begin
      for (int pd = 0; pd < 16; pd += 5) begin
        load_ctrl(ps[0], pd[0], 2'b00, ps[1:0], pd[3:0], 1'b0);
        run(150, "R10 port select");
      end
    end

    // R9 R11: each sleep code with ports active, then wake
    for (int sl = 1; sl < 4; sl++) begin
      load_ctrl(1, 0, 2'b00, 2'b11, 4'b1010, 1'b0);
      run(200, "R10 pre-sleep");
      load_ctrl(1, 0, sl[1:0], 2'b11, 4'b1010, 1'b0);
      run(60, "R9/R11 sleep");
      load_ctrl(1, 0, 2'b00, 2'b01, 4'b0101, 1'b0);
      check_all("R9 wake at common 0");
      run(100, "R9 after wake");
    end

    // R12: control pins ignored without a load strobe
    ctrl_bias_third = 0; ctrl_blank = 1; ctrl_sleep = 2'b11; ctrl_port_sel = 2'b11;
    run(50, "R12 no load no effect");

    // R12: load together with the phase-ending tick
    for (int rep = 0; rep < 4; rep++) begin
      while ((t % PT) != PT - 1) cyc(1'b1, 1'b0);
      load_ctrl(rep[0], 0, 2'b00, 2'b00, 4'h0, 1'b1);
      check_all("R12 load with tick");
      run(20, "R12 after overlap");
    end

    summary();
    $finish;
  end

endmodule